// File: doc/BRIEF.md
# Chroma-Upsampling Colour Converter with Per-Channel Transfer Tables

This block takes a luma/chroma pixel stream in which luma arrives on every sample but only every other sample carries a real chroma pair. It fills in the missing chroma by averaging the neighbouring real samples. It then converts every pixel to the red, green and blue space of the target display through a programmable 3x3 matrix with per-channel offsets. Finally, each of the three results goes through a lookup table of its own that shapes the display transfer curve.

The non-linear shaping is applied only to the matrixed colour channels, never to luma or chroma. The matrix coefficients and offsets sit in a small register bank. Each table has its own write lane. The pipeline has a fixed depth, and the valid and line-start flags travel alongside their pixel.

Top module: `yuv2rgb_pipe`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `out_valid` and `out_sol` are low.
- R2: A pixel sampled at a rising edge appears on the outputs after the fourth rising edge that follows it (five register stages). `out_valid` and `out_sol` stay aligned with that pixel.
- R3: Within a line, sample positions are counted from 0 at the sample that carries `in_sol`. Even positions carry real chroma, which passes through unchanged. The chroma inputs at odd positions are ignored.
- R4: An odd position whose next sample is valid and is not a line start uses chroma equal to (previous real + next real + 1) >> 1, computed separately for U and V.
- R5: An odd position whose next sample is either invalid or starts a new line repeats the previous real chroma.
- R6: Each channel c computes round((Y*Ky + (U-128)*Ku + (V-128)*Kv) / 256) + Off. K is a signed 12-bit value with 8 fraction bits, and Off is a signed 10-bit integer. Rounding adds 128 before an arithmetic shift right by 8.
- R7: Each matrix result is clamped to the range 0..255 before it indexes the table.
- R8: Channel c (0 = red, 1 = green, 2 = blue) reads its own 256 x 8 table. That table is written when `lut_we[c]` is high, at address `lut_addr[8c+7:8c]`, with data `lut_wdata[8c+7:8c]`. The table output is the channel output.
- R9: Before any write, every table holds round(255 * (i/255)^2.2) at index i.
- R10: Register address {channel[1:0], field[1:0]} selects the field. Field 0 is Ky, 1 is Ku, 2 is Kv, and 3 is Off (taken from `cfg_wdata[9:0]`). A write with channel 3 changes nothing.
- R11: After reset, the coefficients (Ky, Ku, Kv) are red 256/0/359, green 256/-88/-183 and blue 256/454/0, and all offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_sol | input | 1 | Input sample is the first of a line |
| in_y | input | 8 | Luma |
| in_u | input | 8 | Blue-difference chroma, offset binary |
| in_v | input | 8 | Red-difference chroma, offset binary |
| cfg_we | input | 1 | Matrix register write strobe |
| cfg_addr | input | 4 | Matrix register address |
| cfg_wdata | input | 12 | Matrix register write data |
| lut_we | input | 3 | Per-channel table write enables |
| lut_addr | input | 24 | Per-channel table write addresses, 8 bits each |
| lut_wdata | input | 24 | Per-channel table write data, 8 bits each |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | Output pixel is the first of a line |
| out_r | output | 8 | Red after transfer table |
| out_g | output | 8 | Green after transfer table |
| out_b | output | 8 | Blue after transfer table |

## Verification
The checks assume that the samples of a line arrive as one unbroken run of valid cycles, and that `in_sol` is raised only together with `in_valid`. This matters because the interpolator looks exactly one clock ahead to find the next real chroma. The checks also assume that table and matrix writes happen only while the pipeline holds no valid pixel. The stimulus meets these assumptions: it sends each line as a continuous burst, sometimes back to back with the next line and sometimes followed by idle cycles, and it idles for at least eight cycles before any register or table write. Odd-position chroma and the data inputs during idle cycles carry deliberately unrelated values.

// File: rtl/yuv2rgb_pkg.sv
`timescale 1ns/1ps
package yuv2rgb_pkg;
  localparam int NCH     = 3;   // red, green, blue
  localparam int NTERM   = 3;   // luma, blue-diff, red-diff
  localparam int CFG_AW  = 4;

  typedef enum logic [1:0] {
    FLD_KY  = 2'd0,
    FLD_KU  = 2'd1,
    FLD_KV  = 2'd2,
    FLD_OFF = 2'd3
  } cfg_field_e;

  // Reset matrix: unity luma gain, standard-definition chroma gains,
  // quantised to the coefficient fraction width.
  function automatic int default_q(int ch, int term, int frac);
    real g;
    g = 0.0;
    case (ch)
      0: g = (term == 0) ? 1.0 : (term == 1) ? 0.0    : 1.402;
      1: g = (term == 0) ? 1.0 : (term == 1) ? -0.344 : -0.714;
      default: g = (term == 0) ? 1.0 : (term == 1) ? 1.772 : 0.0;
    endcase
    return $rtoi(g * (2.0 ** frac) + ((g < 0.0) ? -0.5 : 0.5));
  endfunction
endpackage

// File: rtl/yuv2rgb_cfg.sv
`timescale 1ns/1ps
module yuv2rgb_cfg
  import yuv2rgb_pkg::*;
#(
  parameter int CW   = 12,
  parameter int OW   = 10,
  parameter int FRAC = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [CFG_AW-1:0]          addr,
  input  logic [CW-1:0]              wdata,
  output logic [NCH*NTERM*CW-1:0]    coef_bus,
  output logic [NCH*OW-1:0]          off_bus
);
  logic [CW-1:0] coef_q [NCH][NTERM];
  logic [OW-1:0] off_q  [NCH];
  logic [1:0]    wch;
  cfg_field_e    wfld;

  assign wch  = addr[CFG_AW-1:2];
  assign wfld = cfg_field_e'(addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        for (int t = 0; t < NTERM; t++)
          coef_q[c][t] <= CW'(default_q(c, t, FRAC));
        off_q[c] <= '0;
      end
    end else if (we) begin
      for (int c = 0; c < NCH; c++) begin
        if (wch == 2'(c)) begin
          for (int t = 0; t < NTERM; t++)
            if (wfld == cfg_field_e'(t)) coef_q[c][t] <= wdata;
          if (wfld == FLD_OFF) off_q[c] <= wdata[OW-1:0];
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      for (int t = 0; t < NTERM; t++)
        coef_bus[(c*NTERM+t)*CW +: CW] = coef_q[c][t];
      off_bus[c*OW +: OW] = off_q[c];
    end
  end
endmodule

// File: rtl/yuv2rgb_upsample.sv
`timescale 1ns/1ps
module yuv2rgb_upsample #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_u,
  input  logic [DW-1:0] in_v,
  output logic          up_valid,
  output logic          up_sol,
  output logic [DW-1:0] up_y,
  output logic [DW-1:0] up_u,
  output logic [DW-1:0] up_v
);
  logic          s1_valid, s1_sol, s1_odd, par;
  logic [DW-1:0] s1_y, s1_u, s1_v, last_u, last_v;
  logic [DW:0]   sum_u, sum_v;
  logic          have_next;
  logic [DW-1:0] sel_u, sel_v;

  // Stage 1 control: parity of each sample within its line
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sol   <= 1'b0;
      s1_odd   <= 1'b0;
      par      <= 1'b0;
      up_valid <= 1'b0;
      up_sol   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_sol   <= in_valid & in_sol;
      if (in_valid) begin
        s1_odd <= in_sol ? 1'b0 : par;
        par    <= in_sol ? 1'b1 : ~par;
      end
      up_valid <= s1_valid;
      up_sol   <= s1_sol;
    end
  end

  // The sample one clock behind stage 1 is the right-hand neighbour
  assign have_next = in_valid & ~in_sol;
  assign sum_u = {1'b0, last_u} + {1'b0, in_u} + (DW+1)'(1);
  assign sum_v = {1'b0, last_v} + {1'b0, in_v} + (DW+1)'(1);

  always_comb begin
    if (!s1_odd) begin
      sel_u = s1_u;
      sel_v = s1_v;
    end else if (have_next) begin
      sel_u = sum_u[DW:1];
      sel_v = sum_v[DW:1];
    end else begin
      sel_u = last_u;
      sel_v = last_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_y <= in_y;
    s1_u <= in_u;
    s1_v <= in_v;
    if (s1_valid && !s1_odd) begin
      last_u <= s1_u;
      last_v <= s1_v;
    end
    up_y <= s1_y;
    up_u <= sel_u;
    up_v <= sel_v;
  end
endmodule

// File: rtl/yuv2rgb_matrix.sv
`timescale 1ns/1ps
module yuv2rgb_matrix
  import yuv2rgb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 12,
  parameter int OW   = 10,
  parameter int FRAC = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sol,
  input  logic [DW-1:0]           in_y,
  input  logic [DW-1:0]           in_u,
  input  logic [DW-1:0]           in_v,
  input  logic [NCH*NTERM*CW-1:0] coef_bus,
  input  logic [NCH*OW-1:0]       off_bus,
  output logic                    idx_valid,
  output logic                    idx_sol,
  output logic [NCH*DW-1:0]       idx_bus
);
  localparam int XW   = DW + 1;
  localparam int PW   = XW + CW;
  localparam int SW   = PW + 2;
  localparam int MID  = 2 ** (DW - 1);
  localparam int MAXV = 2 ** DW - 1;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (FRAC - 1));

  logic signed [XW-1:0] tx [NTERM];
  logic                 p_valid, p_sol;

  always_comb begin
    tx[0] = $signed({1'b0, in_y});
    tx[1] = $signed({1'b0, in_u}) - $signed(XW'(MID));
    tx[2] = $signed({1'b0, in_v}) - $signed(XW'(MID));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid   <= 1'b0;
      p_sol     <= 1'b0;
      idx_valid <= 1'b0;
      idx_sol   <= 1'b0;
    end else begin
      p_valid   <= in_valid;
      p_sol     <= in_sol;
      idx_valid <= p_valid;
      idx_sol   <= p_sol;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [CW-1:0] k [NTERM];
    logic signed [PW-1:0] prod [NTERM];
    logic signed [SW-1:0] offs_q, acc, shf;

    always_comb begin
      for (int t = 0; t < NTERM; t++)
        k[t] = $signed(coef_bus[(c*NTERM+t)*CW +: CW]);
    end

    // Stage A: products at full precision, offset aligned to the fraction
    always_ff @(posedge clk) begin
      for (int t = 0; t < NTERM; t++)
        prod[t] <= PW'(tx[t]) * PW'(k[t]);
      offs_q <= SW'($signed(off_bus[c*OW +: OW])) <<< FRAC;
    end

    assign acc = SW'(prod[0]) + SW'(prod[1]) + SW'(prod[2]) + offs_q + HALF;
    assign shf = acc >>> FRAC;

    // Stage B: round, clamp to the table index range
    always_ff @(posedge clk) begin
      if (shf < 0)
        idx_bus[c*DW +: DW] <= '0;
      else if (shf > SW'(MAXV))
        idx_bus[c*DW +: DW] <= DW'(MAXV);
      else
        idx_bus[c*DW +: DW] <= shf[DW-1:0];
    end
  end
endmodule

// File: rtl/yuv2rgb_lut.sv
`timescale 1ns/1ps
module yuv2rgb_lut #(
  parameter int  DW    = 8,
  parameter real GAMMA = 2.2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int  DEPTH = 2 ** DW;
  localparam real TOPV  = real'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DW'($rtoi(TOPV * ((real'(i) / TOPV) ** GAMMA) + 0.5));
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/yuv2rgb_pipe.sv
`timescale 1ns/1ps
module yuv2rgb_pipe
  import yuv2rgb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 12,
  parameter int OW   = 10,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sol,
  input  logic [DW-1:0]        in_y,
  input  logic [DW-1:0]        in_u,
  input  logic [DW-1:0]        in_v,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  input  logic [NCH-1:0]       lut_we,
  input  logic [NCH*DW-1:0]    lut_addr,
  input  logic [NCH*DW-1:0]    lut_wdata,
  output logic                 out_valid,
  output logic                 out_sol,
  output logic [DW-1:0]        out_r,
  output logic [DW-1:0]        out_g,
  output logic [DW-1:0]        out_b
);
  logic [NCH*NTERM*CW-1:0] coef_bus;
  logic [NCH*OW-1:0]       off_bus;
  logic                    up_valid, up_sol;
  logic [DW-1:0]           up_y, up_u, up_v;
  logic                    idx_valid, idx_sol;
  logic [NCH*DW-1:0]       idx_bus, lut_q;

  yuv2rgb_cfg #(.CW(CW), .OW(OW), .FRAC(FRAC)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .coef_bus(coef_bus), .off_bus(off_bus)
  );

  yuv2rgb_upsample #(.DW(DW)) u_up (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .up_valid(up_valid), .up_sol(up_sol), .up_y(up_y), .up_u(up_u), .up_v(up_v)
  );

  yuv2rgb_matrix #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC)) u_mtx (
    .clk(clk), .rst(rst), .in_valid(up_valid), .in_sol(up_sol),
    .in_y(up_y), .in_u(up_u), .in_v(up_v),
    .coef_bus(coef_bus), .off_bus(off_bus),
    .idx_valid(idx_valid), .idx_sol(idx_sol), .idx_bus(idx_bus)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lut
    yuv2rgb_lut #(.DW(DW)) u_lut (
      .clk(clk), .we(lut_we[c]),
      .waddr(lut_addr[c*DW +: DW]), .wdata(lut_wdata[c*DW +: DW]),
      .raddr(idx_bus[c*DW +: DW]), .rdata(lut_q[c*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
    end else begin
      out_valid <= idx_valid;
      out_sol   <= idx_sol;
    end
  end

  assign out_r = lut_q[0*DW +: DW];
  assign out_g = lut_q[1*DW +: DW];
  assign out_b = lut_q[2*DW +: DW];
endmodule

// File: rtl/yuv2rgb_checker.sv
`timescale 1ns/1ps
module yuv2rgb_checker
  import yuv2rgb_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 12,
  parameter int OW = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_sol,
  input logic [DW-1:0]           in_u,
  input logic                    out_valid,
  input logic                    out_sol,
  input logic                    up_valid,
  input logic                    up_sol,
  input logic [DW-1:0]           up_u,
  input logic                    cfg_we,
  input logic [CFG_AW-1:0]       cfg_addr,
  input logic [NCH*NTERM*CW-1:0] coef_bus,
  input logic [NCH*OW-1:0]       off_bus
);
  // Edges since reset, saturating; guards every $past window
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5) |-> (out_valid == $past(in_valid, 5))); // R2

  AST_SOL_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5) |-> (out_sol == $past(in_valid & in_sol, 5))); // R2

  AST_SOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid); // R2

  AST_EVEN_CHROMA_PASS: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && up_valid && up_sol) |-> (up_u == $past(in_u, 2))); // R3

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr[CFG_AW-1:2] == 2'b11) |=> ($stable(coef_bus) && $stable(off_bus))); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sol)); // R1
endmodule

bind yuv2rgb_pipe yuv2rgb_checker #(.DW(DW), .CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_u(in_u),
  .out_valid(out_valid), .out_sol(out_sol),
  .up_valid(up_valid), .up_sol(up_sol), .up_u(up_u),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .coef_bus(coef_bus), .off_bus(off_bus)
);

// File: tb/test_yuv2rgb_pipe.sv
`timescale 1ns/1ps
module test_yuv2rgb_pipe;
  localparam int HN = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sol = 1'b0;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [2:0]  lut_we = '0;
  logic [23:0] lut_addr = '0, lut_wdata = '0;
  logic        out_valid, out_sol;
  logic [7:0]  out_r, out_g, out_b;

  yuv2rgb_pipe i_yuv2rgb_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
    .out_valid(out_valid), .out_sol(out_sol),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  always #2 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R2";
  bit    started = 0, done = 0;

  // Reference model state
  int  mcoef [3][3];
  int  moff  [3];
  int  mlut  [3][256];
  bit  hv [HN], hs [HN], hodd [HN], hr [HN];
  int  hy [HN], hu [HN], hw [HN], hlu [HN], hlw [HN];
  int  cyc = 0;
  bit  par_m = 0;
  int  lu_m = 0, lw_m = 0;

  function automatic int gamma_of(int i);
    return $rtoi(255.0 * ((real'(i) / 255.0) ** 2.2) + 0.5);
  endfunction

  function automatic int clamp8(int x);
    return (x < 0) ? 0 : (x > 255) ? 255 : x;
  endfunction

  initial begin
    // R11 reset matrix, R9 reset tables
    mcoef[0][0] = 256; mcoef[0][1] = 0;   mcoef[0][2] = 359;
    mcoef[1][0] = 256; mcoef[1][1] = -88; mcoef[1][2] = -183;
    mcoef[2][0] = 256; mcoef[2][1] = 454; mcoef[2][2] = 0;
    for (int c = 0; c < 3; c++) begin
      moff[c] = 0;
      for (int i = 0; i < 256; i++) mlut[c][i] = gamma_of(i);
    end
  end

  // Record what the design samples at each edge
  always @(posedge clk) begin
    if (cyc < HN) begin
      hv[cyc] = in_valid;
      hs[cyc] = in_valid & in_sol;
      hr[cyc] = rst;
      hy[cyc] = in_y; hu[cyc] = in_u; hw[cyc] = in_v;
      hodd[cyc] = 0;
      if (rst) par_m = 0;
      else if (in_valid) begin
        hodd[cyc] = in_sol ? 0 : par_m;
        par_m     = in_sol ? 1 : !par_m;
        if (!hodd[cyc]) begin lu_m = in_u; lw_m = in_v; end
      end
      hlu[cyc] = lu_m; hlw[cyc] = lw_m;
    end
    cyc++;
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    int p, eu, ew, s, idx;
    bit ev, es;
    int exp_c [3];
    if (started && !done && cyc >= 1 && cyc < HN) begin
      p  = cyc - 5;
      ev = (p >= 0) && hv[p] && !hr[p];
      es = ev && hs[p];
      n_cmp++;
      if (out_valid !== ev || out_sol !== es) begin
        n_bad++;
        $display("FAIL R2: valid/sol=%b%b expected %b%b at cycle %0d", out_valid, out_sol, ev, es, cyc);
      end
      if (ev) begin
        if (!hodd[p]) begin eu = hu[p]; ew = hw[p]; end
        else if (hv[p+1] && !hs[p+1]) begin
          eu = (hlu[p] + hu[p+1] + 1) / 2;
          ew = (hlw[p] + hw[p+1] + 1) / 2;
        end else begin eu = hlu[p]; ew = hlw[p]; end
        for (int c = 0; c < 3; c++) begin
          s = hy[p] * mcoef[c][0] + (eu - 128) * mcoef[c][1] + (ew - 128) * mcoef[c][2] + moff[c] * 256;
          idx = clamp8((s + 128) >>> 8);
          exp_c[c] = mlut[c][idx];
        end
        n_cmp++;
        if (out_r !== 8'(exp_c[0]) || out_g !== 8'(exp_c[1]) || out_b !== 8'(exp_c[2])) begin
          n_bad++;
          $display("FAIL %s: rgb=%02h %02h %02h expected %02h %02h %02h at cycle %0d",
                   cur_req, out_r, out_g, out_b, exp_c[0], exp_c[1], exp_c[2], cyc);
        end
      end
    end
  end

  task automatic push(input bit sol, input int y, input int u, input int v);
    @(negedge clk);
    in_valid = 1'b1; in_sol = sol;
    in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_sol = 1'b0;
      in_y = 8'h5C; in_u = 8'hE1; in_v = 8'h17;
    end
  endtask

  // Odd positions carry unrelated chroma (R3: must be ignored)
  task automatic line_gen(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0)
        push(i == 0, (seed*41 + i*23) & 255, (seed*59 + i*37 + 17) & 255, (seed*13 + i*91 + 200) & 255);
      else
        push(1'b0, (seed*41 + i*23) & 255, (i*13 + seed) ^ 8'hC3, (i*71 + seed*5) ^ 8'h3C);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    int ch, f, val;
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 12'(data);
    ch = addr >> 2; f = addr & 3;
    if (ch < 3) begin
      if (f < 3) begin val = data & 12'hFFF; if (val >= 2048) val -= 4096; mcoef[ch][f] = val; end
      else begin val = data & 10'h3FF; if (val >= 512) val -= 1024; moff[ch] = val; end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lut_load(input int mode);
    int d [3];
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      if (mode == 0) begin d[0] = a; d[1] = a; d[2] = a; end
      else begin d[0] = 255 - a; d[1] = a ^ 8'h5A; d[2] = (a * 7) & 255; end
      lut_we = 3'b111;
      lut_addr = {8'(a), 8'(a), 8'(a)};
      lut_wdata = {8'(d[2]), 8'(d[1]), 8'(d[0])};
      for (int c = 0; c < 3; c++) mlut[c][a] = d[c];
    end
    @(negedge clk);
    lut_we = 3'b000;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL R2: watchdog expired at cycle %0d, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    n_cmp++;  // R1 outputs quiet in reset
    if (out_valid !== 1'b0 || out_sol !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: valid/sol=%b%b expected 00 during reset", out_valid, out_sol);
    end
    rst = 1'b0;
    started = 1;

    // R9 R11: reset matrix and reset tables, grey ramp then coloured lines
    cur_req = "R9 R11";
    for (int i = 0; i < 32; i++) push(i == 0, i * 8, 128, 128);
    idle(2);
    line_gen(12, 3);
    line_gen(9, 6);
    idle(8);

    // R3 R4 R5 R6 R8 R10: matrix passes Y, U, V straight to R, G, B
    cur_req = "R3 R4 R5 R6 R8 R10";
    cfg_write(0, 256);  cfg_write(1, 0);     cfg_write(2, 0);   cfg_write(3, 0);
    cfg_write(4, 0);    cfg_write(5, 256);   cfg_write(6, 0);   cfg_write(7, 128);
    cfg_write(8, 0);    cfg_write(9, 0);     cfg_write(10, 256); cfg_write(11, 128);
    cfg_write(12, 12'h7FF); cfg_write(13, 12'h800); cfg_write(15, 12'h1FF);  // R10 ignored
    lut_load(0);
    idle(4);
    line_gen(10, 1);          // even length, last odd pixel followed by idle
    idle(3);
    line_gen(7, 2);           // odd length, ends on a real sample
    idle(1);
    line_gen(6, 4);           // back to back: next line start ends this one
    line_gen(8, 5);
    line_gen(2, 7);
    idle(8);

    // R7 R8: large gains and offsets force both clamp limits; distinct tables
    cur_req = "R7 R8";
    cfg_write(0, 2047); cfg_write(3, -300);
    cfg_write(4, -2048); cfg_write(5, 0);  cfg_write(7, 511);
    cfg_write(8, 256);   cfg_write(9, 700); cfg_write(10, -700); cfg_write(11, -512);
    lut_load(1);
    idle(4);
    for (int i = 0; i < 52; i++) push(i == 0, i * 5, (i * 29) & 255, (255 - i * 17) & 255);
    idle(2);
    line_gen(16, 9);
    idle(8);

    // R10: writes to the unused channel slot leave the matrix unchanged
    cur_req = "R10";
    cfg_write(12, 12'h123); cfg_write(14, 12'hABC); cfg_write(15, 12'h3FF);
    idle(2);
    line_gen(14, 11);
    idle(10);
    finish_run();
  end
endmodule